// File: doc/BRIEF.md
# Filtered Edge Input Capture Unit

This block watches one asynchronous input pin and records the moment a chosen transition arrives on it. The pin is first brought into the clock domain by a short flop chain. It can then be passed through a glitch filter that only moves its output once the pin has shown the same level on four consecutive clocks. A transition detector picks out rising or falling changes, as selected by a control bit. On a qualifying transition it copies a free-running counter value, supplied from outside, into a capture register and sets a sticky flag.

The flag stays set until software writes a one to the clear input. The interrupt output is the flag gated by an interrupt enable. The counter itself and any register access path sit outside the block. The block is used to time-stamp external events such as pulse widths or periods: a counter is wired to `cntValue` and the captured values are read after each flag.

Top module: `icu_capture`

## Requirements
- R1: While reset is asserted and right after it, `capValue` is 0, and `capFlag` and `irq` are 0.
- R2: With `edgeRising`=1, a low-to-high change on the pin causes a capture and a high-to-low change does not.
- R3: With `edgeRising`=0, a high-to-low change on the pin causes a capture and a low-to-high change does not.
- R4: With the filter off, a pin change applied before clock edge k is captured at edge k+2. `capValue` then holds the `cntValue` present at that edge, and `capFlag` is 1 after it.
- R5: With `filterEnable`=1, a pin level held for fewer than four clocks is ignored. A level held for four clocks or more is captured exactly four clocks later than with the filter off.
- R6: With `capEnable`=0, no pin change alters `capValue` or `capFlag`.
- R7: `capFlag` stays at 1 after a capture until `flagClear` is 1 at a clock edge. A capture at the same edge as a clear leaves the flag at 1.
- R8: A capture while `capFlag` is already 1 still replaces `capValue` with the new counter value.
- R9: `irq` equals `capFlag` AND `irqEnable`.
- R10: Changing `edgeRising` while the pin level is steady never causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Asynchronous capture pin |
| capEnable | input | 1 | 1 allows captures |
| filterEnable | input | 1 | 1 routes the pin through the four-sample filter |
| edgeRising | input | 1 | 1 selects rising transitions, 0 selects falling |
| cntValue | input | 16 | Running counter value to be sampled |
| flagClear | input | 1 | 1 at an edge clears the capture flag |
| irqEnable | input | 1 | Gates the flag onto `irq` |
| capValue | output | 16 | Last captured counter value |
| capFlag | output | 1 | Sticky capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
A pin change made at the falling clock edge before rising edge k is due in `capValue` and `capFlag` after edge k+2 with the filter off, and after edge k+6 with it on. The counter value expected is the one driven just before that edge. The bench advances one cycle at a time through a single task that also drives the counter, and it samples every output at the falling edge after the due rising edge. Pin levels in the random part are held for at least nine cycles, so each change is one clean event that a bench function can classify.

// File: rtl/icu_pkg.sv
package icu_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;
  } icuStrobe_t;
endpackage

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capPin,
  input  logic       capEnable,
  input  logic       filterEnable,
  input  logic       edgeRising,
  output icuStrobe_t strobe
);
  localparam int HIST_W = FILTER_LEN - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLevel;
  logic [HIST_W-1:0]      hist;
  logic [FILTER_LEN-1:0]  window;
  logic                   filtLevel;
  logic                   selLevel;
  logic                   prevLevel;
  logic                   riseSeen;
  logic                   fallSeen;

  // Synchronizer chain, fixed latency whatever the filter setting
  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[st] <= 1'b0;
        else if (st == 0) syncChain[st] <= capPin;
        else syncChain[st] <= syncChain[(st == 0) ? 0 : st-1];
      end
    end
  endgenerate
  assign syncLevel = syncChain[SYNC_STAGES-1];

  // History of the previous synchronized samples
  generate
    if (HIST_W == 1) begin : g_hist_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else hist <= syncLevel;
      end
    end else begin : g_hist_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else hist <= {hist[HIST_W-2:0], syncLevel};
      end
    end
  endgenerate

  assign window = {hist, syncLevel};

  // Filter output moves only when the whole window agrees
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtLevel <= 1'b0;
    else if (&window) filtLevel <= 1'b1;
    else if (~|window) filtLevel <= 1'b0;
  end

  assign selLevel = filterEnable ? filtLevel : syncLevel;

  // Edge detection against the previous selected level only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else prevLevel <= selLevel;
  end

  assign riseSeen = selLevel & ~prevLevel;
  assign fallSeen = ~selLevel & prevLevel;

  always_comb begin
    strobe.capture = capEnable & (edgeRising ? riseSeen : fallSeen);
  end

  // R5: the filter output only changes after a run of equal samples
  p_filter_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    (filtLevel != $past(filtLevel)) |->
      ($past(syncLevel) == filtLevel && $past(syncLevel, 2) == filtLevel));

  // R10: a steady level never yields a capture, whatever the edge select does
  p_no_edge_no_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    (selLevel == $past(selLevel)) |-> !strobe.capture);

  // R2: rising selection only fires on a low-to-high change
  p_rising_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && edgeRising) |-> (selLevel && !$past(selLevel)));

  // R3: falling selection only fires on a high-to-low change
  p_falling_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !edgeRising) |-> (!selLevel && $past(selLevel)));
endmodule

// File: rtl/icu_datapath.sv
module icu_datapath
  import icu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  icuStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntValue,
  input  logic             flagClear,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag
);
  // Capture register: overwritten on every capture, flag or not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capValue <= '0;
    else if (strobe.capture) capValue <= cntValue;
  end

  // Sticky flag: a set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capFlag <= 1'b0;
    else if (strobe.capture) capFlag <= 1'b1;
    else if (flagClear) capFlag <= 1'b0;
  end

  // R4, R8: the register takes the counter value seen at the capture edge
  p_value_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (capValue == $past(cntValue)));

  // R7: a capture always leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> capFlag);

  // R7: a clear without a capture drops the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !strobe.capture) |=> !capFlag);

  // R7: without capture or clear the flag holds
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!flagClear && !strobe.capture) |=> $stable(capFlag));
endmodule

// File: rtl/icu_capture.sv
module icu_capture
  import icu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  logic             capEnable,
  input  logic             filterEnable,
  input  logic             edgeRising,
  input  logic [CNT_W-1:0] cntValue,
  input  logic             flagClear,
  input  logic             irqEnable,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             irq
);
  icuStrobe_t strobe;

  icu_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN (FILTER_LEN)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .capPin      (capPin),
    .capEnable   (capEnable),
    .filterEnable(filterEnable),
    .edgeRising  (edgeRising),
    .strobe      (strobe)
  );

  icu_datapath #(
    .CNT_W(CNT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntValue (cntValue),
    .flagClear(flagClear),
    .capValue (capValue),
    .capFlag  (capFlag)
  );

  assign irq = capFlag & irqEnable;

  // R6: with captures disabled the register cannot move
  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !capEnable |=> $stable(capValue));

  // R6: with captures disabled the flag cannot rise
  p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!capEnable && !capFlag) |=> !capFlag);
endmodule

// File: tb/tb_icu_capture.sv
module tb_icu_capture;
  logic        clk = 1'b0;
  logic        rstN;
  logic        capPin, capEnable, filterEnable, edgeRising;
  logic [15:0] cntValue;
  logic        flagClear, irqEnable;
  logic [15:0] capValue;
  logic        capFlag, irq;

  int errors = 0;
  int checks = 0;
  int tick   = 0;
  bit done   = 0;

  logic [15:0] expVal;
  logic        expFlag;
  logic        curPin;

  always #5 clk = ~clk;

  icu_capture dut (
    .clk(clk), .rstN(rstN), .capPin(capPin), .capEnable(capEnable),
    .filterEnable(filterEnable), .edgeRising(edgeRising), .cntValue(cntValue),
    .flagClear(flagClear), .irqEnable(irqEnable), .capValue(capValue),
    .capFlag(capFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: advance to the falling edge and drive the counter
  task automatic nextCycle();
    @(negedge clk);
    tick++;
    cntValue = tick[15:0];
  endtask

  function automatic bit isTrigger(input logic oldL, input logic newL,
                                   input logic rise, input logic en);
    return en && (oldL != newL) && (rise ? newL : !newL);
  endfunction

  function automatic int latencyOf(input logic filt);
    return filt ? 7 : 3;
  endfunction

  // One clean pin event followed by a settle period
  task automatic segment(input logic newPin, input logic rise, input logic en,
                         input logic filt, input logic doClear, input logic irqEn);
    int n;
    int lat;
    bit trig;
    filterEnable = filt;
    edgeRising   = rise;
    capEnable    = en;
    irqEnable    = irqEn;
    capPin       = newPin;
    n    = tick;
    lat  = latencyOf(filt);
    trig = isTrigger(curPin, newPin, rise, en);
    repeat (lat) nextCycle();
    if (trig) begin
      expVal  = 16'(n + lat - 1);
      expFlag = 1'b1;
    end
    check(trig ? "R4 capture value" : "R6/R2/R3 value unchanged", capValue, expVal);
    check(rise ? "R2 flag" : "R3 flag", capFlag, expFlag);
    check("R9 irq gating", irq, expFlag & irqEn);
    curPin = newPin;
    if (doClear) begin
      flagClear = 1'b1;
      nextCycle();
      flagClear = 1'b0;
      expFlag   = 1'b0;
      check("R7 flag cleared", capFlag, 1'b0);
    end
    repeat (9) nextCycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1ce0));
    rstN = 1'b0; capPin = 1'b0; capEnable = 1'b0; filterEnable = 1'b0;
    edgeRising = 1'b1; cntValue = 16'd0; flagClear = 1'b0; irqEnable = 1'b1;
    expVal = 16'd0; expFlag = 1'b0; curPin = 1'b0;
    repeat (3) nextCycle();
    check("R1 reset value", capValue, 16'd0);
    check("R1 reset flag", capFlag, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    rstN = 1'b1;
    repeat (4) nextCycle();
    check("R1 after reset", {capFlag, capValue}, 17'd0);

    // R2 rising captured, falling ignored
    segment(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    segment(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    // R3 falling captured, rising ignored
    segment(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    segment(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8 capture with flag still set overwrites; R7 flag stays set meanwhile
    segment(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 flag sticky", capFlag, 1'b1);
    segment(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R8 overwrite value", capValue, expVal);
    // R6 disabled
    segment(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    segment(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);

    // R5 short pulse (3 clocks) with filter is ignored
    begin
      logic [15:0] held;
      held = capValue;
      filterEnable = 1'b1; edgeRising = 1'b1; capEnable = 1'b1;
      capPin = 1'b1;
      repeat (3) nextCycle();
      capPin = 1'b0;
      repeat (12) nextCycle();
      check("R5 short pulse value", capValue, held);
      check("R5 short pulse flag", capFlag, 1'b0);
    end
    // R5 four-clock pulse passes, four clocks later than unfiltered
    begin
      int n;
      n = tick;
      capPin = 1'b1;
      repeat (4) nextCycle();
      capPin = 1'b0;
      repeat (2) nextCycle();
      check("R5 not yet captured", capFlag, 1'b0);
      nextCycle();
      check("R5 filtered capture value", capValue, 16'(n + 6));
      check("R5 filtered capture flag", capFlag, 1'b1);
      expVal = 16'(n + 6); expFlag = 1'b1;
      repeat (12) nextCycle();
      check("R5 trailing fall ignored", capValue, expVal);
      curPin = 1'b0;
    end

    // R7 capture and clear in the same cycle: set wins
    begin
      int n;
      filterEnable = 1'b0; edgeRising = 1'b1; capEnable = 1'b1;
      n = tick;
      capPin = 1'b1;
      nextCycle(); nextCycle();
      flagClear = 1'b1;
      nextCycle();
      flagClear = 1'b0;
      check("R7 set beats clear", capFlag, 1'b1);
      check("R4 value at same-cycle clear", capValue, 16'(n + 2));
      expVal = 16'(n + 2);
      curPin = 1'b1;
      flagClear = 1'b1; nextCycle(); flagClear = 1'b0;
      expFlag = 1'b0;
      repeat (8) nextCycle();
    end

    // R10 toggling the edge select with the pin steady high
    for (int i = 0; i < 8; i++) begin
      edgeRising = ~edgeRising;
      nextCycle();
    end
    repeat (4) nextCycle();
    check("R10 flag after select toggles", capFlag, 1'b0);
    check("R10 value after select toggles", capValue, expVal);

    // Random segments
    for (int i = 0; i < 60; i++) begin
      segment(1'($urandom), 1'($urandom), ($urandom % 4) != 0,
              1'($urandom), ($urandom % 3) != 0, 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule